// File: doc/BRIEF.md
# Serial Register Access Slave

This block terminates a three-wire shift-and-strobe serial port inside a larger chip. A host frames each transfer by pulling the enable line low, clocks in sixteen bits most significant first, and then raises the enable line to commit the frame. Each frame holds a 9-bit data word, then a 4-bit register address, then a 3-bit chip address. When the chip address equals the block's fixed identity and exactly sixteen bits were received, the block emits a one-cycle write strobe with the address and data toward register storage that lives outside the block.

In every frame the block also returns a register value on its serial output. The register it returns is chosen by a read pointer. The pointer is a shadow of the low four data bits of the last frame committed to register 0. To read an arbitrary register, the host first writes the target address into register 0. The target's value then comes out on the serial output during the following frame. The output enable falls as soon as a received chip address bit disagrees with the identity, which releases the line for other slaves on the same wires.

The serial pins are asynchronous to the system clock. They pass through two-flop synchronisers, and edges are detected in the system clock domain. The controller is a three-state machine:

- IDLE waits for the enable to fall. That edge clears the receive counter and shift register, loads the return word and enters SHIFT.
- SHIFT takes one bit per serial clock rising edge. When the enable rises, it moves to COMMIT if the frame is valid and back to IDLE otherwise, which discards the frame.
- COMMIT drives the write strobe for one cycle and returns to IDLE.

Top module: `ser_reg_slave`

## Requirements
- R1: Bits are sampled on serial clock rising edges, most significant first. Bits 1 to 9 form the data word, bits 10 to 13 form the register address and bits 14 to 16 form the chip address. These land on wr_data, wr_addr and the identity compare.
- R2: When the enable rises after exactly 16 bits whose chip address is 3'b001, wr_stb is high for exactly one system clock cycle, with wr_addr and wr_data carrying the frame's fields.
- R3: A frame whose chip address is not 3'b001 produces no write strobe, and the target register keeps its value.
- R4: A frame with fewer or more than 16 sampled bits produces no write strobe, whatever its content.
- R5: In each frame a 16-bit return word is captured at the enable's falling edge. The word is seven zeros followed by rd_data, the register selected by rd_addr. After the k-th rising serial clock edge of the frame (k = 1..16), sdo_data shows bit 16-k of that word.
- R6: rd_addr is 0 after reset. It takes data bits [3:0] of every committed write to register 0. Committed writes to other registers leave it unchanged.
- R7: sdo_oe is high from the start of a frame until a received chip address bit differs from the matching bit of 3'b001. It is low while the enable stays high.
- R8: After reset, wr_stb and sdo_oe are low and rd_addr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_pin | input | 1 | Serial clock from the host, asynchronous |
| sdi_pin | input | 1 | Serial data from the host, asynchronous |
| sen_pin | input | 1 | Frame enable, low during a frame and high to commit |
| sdo_data | output | 1 | Serial return data |
| sdo_oe | output | 1 | Output enable for the serial return pad; low releases the line |
| wr_stb | output | 1 | One-cycle write strobe to register storage |
| wr_addr | output | 4 | Register address of the committed frame |
| wr_data | output | 9 | Data word of the committed frame |
| rd_addr | output | 4 | Read pointer toward register storage |
| rd_data | input | 9 | Contents of the register at rd_addr |

## Verification
The bench targets two-frame reads, where the pointer written in one frame must select the word returned in the next. A design that updated the pointer early, or from the wrong field, would return the wrong register. It sends chip addresses that mismatch in the first and in the last chip bit, and then reads the target register back. A design that compared only part of the identity would write the register, and one that never dropped the enable would hold the shared line. Ten-bit and seventeen-bit frames carrying a valid identity check that a design counting loosely does not commit garbage.

// File: rtl/ser_reg_slave_pkg.sv
package ser_reg_slave_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2
    } ssl_state_t;
endpackage

// File: rtl/ssl_pin_sync.sv
module ssl_pin_sync #(
    parameter int   STAGES   = 2,
    parameter logic RST_VAL  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
            prev  <= RST_VAL;
        end else begin
            chain <= {chain[STAGES-2:0], pin};
            prev  <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~prev;
    assign fall  = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/ssl_rx.sv
module ssl_rx #(
    parameter int             DATA_W  = 9,
    parameter int             ADDR_W  = 4,
    parameter int             CHIP_W  = 3,
    parameter logic [CHIP_W-1:0] CHIP_ID = 3'b001,
    localparam int            FRAME_W = DATA_W + ADDR_W + CHIP_W,
    localparam int            CNT_W   = $clog2(FRAME_W + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               bit_stb,
    input  logic               sdi_bit,
    output logic [FRAME_W-1:0] frame,
    output logic [CNT_W-1:0]   count,
    output logic               chip_ok
);
    localparam logic [CNT_W-1:0] CNT_MAX   = CNT_W'(FRAME_W + 1);
    localparam logic [CNT_W-1:0] CHIP_FIRST = CNT_W'(DATA_W + ADDR_W);
    localparam logic [CNT_W-1:0] LAST_POS  = CNT_W'(FRAME_W - 1);

    logic [CHIP_W-1:0] id_shift;
    logic              in_chip_field;

    assign in_chip_field = (count >= CHIP_FIRST) && (count <= LAST_POS);
    assign id_shift      = CHIP_ID >> (LAST_POS - count);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame   <= '0;
            count   <= '0;
            chip_ok <= 1'b0;
        end else if (start) begin
            frame   <= '0;
            count   <= '0;
            chip_ok <= 1'b1;
        end else if (bit_stb) begin
            frame <= {frame[FRAME_W-2:0], sdi_bit};
            if (count < CNT_MAX) begin
                count <= count + 1'b1;
            end
            if (in_chip_field && (sdi_bit != id_shift[0])) begin
                chip_ok <= 1'b0;
            end
        end
    end

    AST_CHIP_OK_FALLS_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chip_ok) |-> $past(bit_stb)); // R7
endmodule

// File: rtl/ssl_tx.sv
module ssl_tx #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              bit_stb,
    output logic              sdo_bit
);
    logic [WORD_W-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh      <= '0;
            sdo_bit <= 1'b0;
        end else if (load) begin
            sh      <= load_word;
            sdo_bit <= 1'b0;
        end else if (bit_stb) begin
            sdo_bit <= sh[WORD_W-1];
            sh      <= {sh[WORD_W-2:0], 1'b0};
        end
    end

    AST_SDO_HOLDS_BETWEEN_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !bit_stb) |=> $stable(sdo_bit)); // R5
endmodule

// File: rtl/ser_reg_slave.sv
module ser_reg_slave
    import ser_reg_slave_pkg::*;
#(
    parameter int              DATA_W    = 9,
    parameter int              ADDR_W    = 4,
    parameter int              CHIP_W    = 3,
    parameter logic [CHIP_W-1:0] CHIP_ID = 3'b001,
    parameter int              SYNC_STG  = 2,
    parameter int              PTR_REG   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_pin,
    input  logic              sdi_pin,
    input  logic              sen_pin,
    output logic              sdo_data,
    output logic              sdo_oe,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data
);
    localparam int FRAME_W = DATA_W + ADDR_W + CHIP_W;
    localparam int CNT_W   = $clog2(FRAME_W + 2);
    localparam int NPINS   = 3;
    localparam logic [NPINS-1:0] PIN_RST = 3'b100;

    logic [NPINS-1:0] pin_vec, lvl_vec, rise_vec, fall_vec;
    logic             sclk_rise, sdi_lvl, sen_lvl, sen_rise, sen_fall;

    assign pin_vec = {sen_pin, sdi_pin, sclk_pin};

    for (genvar g = 0; g < NPINS; g++) begin : g_sync
        ssl_pin_sync #(.STAGES(SYNC_STG), .RST_VAL(PIN_RST[g])) i_sync (
            .clk(clk), .rst_n(rst_n), .pin(pin_vec[g]),
            .level(lvl_vec[g]), .rise(rise_vec[g]), .fall(fall_vec[g]));
    end

    assign sclk_rise = rise_vec[0];
    assign sdi_lvl   = lvl_vec[1];
    assign sen_lvl   = lvl_vec[2];
    assign sen_rise  = rise_vec[2];
    assign sen_fall  = fall_vec[2];

    ssl_state_t        state, state_nx;
    logic              frame_start, bit_take, frame_valid;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]  count;
    logic              chip_ok;
    logic [ADDR_W-1:0] ptr;

    assign frame_start = (state == ST_IDLE) && sen_fall;
    assign bit_take    = (state == ST_SHIFT) && sclk_rise;
    assign frame_valid = (count == CNT_W'(FRAME_W)) && (frame[CHIP_W-1:0] == CHIP_ID);

    ssl_rx #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CHIP_W(CHIP_W), .CHIP_ID(CHIP_ID)) i_rx (
        .clk(clk), .rst_n(rst_n), .start(frame_start), .bit_stb(bit_take),
        .sdi_bit(sdi_lvl), .frame(frame), .count(count), .chip_ok(chip_ok));

    ssl_tx #(.WORD_W(FRAME_W)) i_tx (
        .clk(clk), .rst_n(rst_n), .load(frame_start),
        .load_word({{(FRAME_W-DATA_W){1'b0}}, rd_data}),
        .bit_stb(bit_take), .sdo_bit(sdo_data));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (sen_fall) state_nx = ST_SHIFT;
            ST_SHIFT:  if (sen_rise) state_nx = frame_valid ? ST_COMMIT : ST_IDLE;
            ST_COMMIT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        wr_stb  = 1'b0;
        sdo_oe  = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_SHIFT:  sdo_oe = chip_ok;
            ST_COMMIT: wr_stb = 1'b1;
            default:   ;
        endcase
        wr_data = frame[FRAME_W-1 -: DATA_W];
        wr_addr = frame[CHIP_W +: ADDR_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if ((state == ST_COMMIT) && (wr_addr == ADDR_W'(PTR_REG))) begin
            ptr <= wr_data[ADDR_W-1:0];
        end
    end

    assign rd_addr = ptr;

    AST_STB_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb); // R2
    AST_STB_FOLLOWS_SEN_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_stb) |-> $past(sen_rise)); // R2
    AST_STB_NEEDS_ID_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> chip_ok); // R3
    AST_STB_NEEDS_FULL_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (count == CNT_W'(FRAME_W))); // R4
    AST_PTR_ONLY_ON_REG0: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_addr) |-> $past(wr_stb && (wr_addr == ADDR_W'(PTR_REG)))); // R6
    AST_OE_LOW_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sen_lvl && $past(sen_lvl)) |-> !sdo_oe); // R7
endmodule

// File: tb/test_ser_reg_slave.sv
module test_ser_reg_slave;
    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk_pin = 1'b0, sdi_pin = 1'b0, sen_pin = 1'b1;
    logic       sdo_data, sdo_oe, wr_stb;
    logic [3:0] wr_addr, rd_addr;
    logic [8:0] wr_data, rd_data;

    logic [8:0]  mem [16];
    logic [8:0]  exp_mem [16];
    logic [3:0]  exp_ptr = 4'd0;
    logic [12:0] exp_q [$];
    int          n_checks = 0, n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    ser_reg_slave i_ser_reg_slave (
        .clk(clk), .rst_n(rst_n), .sclk_pin(sclk_pin), .sdi_pin(sdi_pin), .sen_pin(sen_pin),
        .sdo_data(sdo_data), .sdo_oe(sdo_oe), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data));

    assign rd_data = mem[rd_addr];

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pops expected writes as strobes appear and acts as register storage
    always @(negedge clk) begin
        if (rst_n && wr_stb) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R3 or R4 unexpected write actual=%h expected=none", {wr_addr, wr_data});
            end else begin
                logic [12:0] e;
                e = exp_q.pop_front();
                if ({wr_addr, wr_data} !== e) begin
                    n_fail++;
                    $display("FAIL R1 R2 write actual=%h expected=%h", {wr_addr, wr_data}, e);
                end
            end
            mem[wr_addr] = wr_data;
        end
    end

    task automatic send(input logic [8:0] d, input logic [3:0] a, input logic [2:0] c, input int nbits);
        logic [15:0] w, ret;
        logic        oe_exp, valid;
        w      = {d, a, c};
        ret    = {7'b0, exp_mem[exp_ptr]};
        valid  = (nbits == 16) && (c == 3'b001);
        oe_exp = 1'b1;
        sen_pin = 1'b0;
        wclk(H);
        for (int i = 0; i < nbits; i++) begin
            sdi_pin = (i < 16) ? w[15-i] : 1'b0;
            wclk(H);
            sclk_pin = 1'b1;
            if (i >= 13 && i < 16 && (w[15-i] != (3'b001 >> (15 - i)) % 2)) oe_exp = 1'b0;
            wclk(H);
            if (i < 16) check("R5 sdo bit", {15'b0, sdo_data}, {15'b0, ret[15-i]});
            check("R7 oe in frame", {15'b0, sdo_oe}, {15'b0, oe_exp});
            sclk_pin = 1'b0;
        end
        wclk(H);
        if (valid) begin
            exp_q.push_back({a, d});
            exp_mem[a] = d;
            if (a == 4'd0) exp_ptr = d[3:0];
        end
        sen_pin = 1'b1;
        wclk(2 * H);
        check("R7 oe idle", {15'b0, sdo_oe}, 16'd0);
        check("R6 pointer", {12'b0, rd_addr}, {12'b0, exp_ptr});
        check("R2 queue drained", 16'(exp_q.size()), 16'd0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            mem[i] = 9'd0;
            exp_mem[i] = 9'd0;
        end
        wclk(4);
        rst_n = 1'b1;
        wclk(2);
        check("R8 wr_stb", {15'b0, wr_stb}, 16'd0);
        check("R8 sdo_oe", {15'b0, sdo_oe}, 16'd0);
        check("R8 rd_addr", {12'b0, rd_addr}, 16'd0);

        send(9'h1A5, 4'd5, 3'b001, 16);   // R1 R2 plain write
        send(9'h005, 4'd0, 3'b001, 16);   // R6 pointer to 5
        send(9'h0F0, 4'd3, 3'b001, 16);   // R5 returns reg 5, R6 pointer kept
        send(9'h000, 4'd5, 3'b101, 16);   // R3 mismatch in first chip bit, R7
        send(9'h000, 4'd5, 3'b000, 16);   // R3 mismatch in last chip bit, R7
        send(9'h003, 4'd0, 3'b001, 16);   // R5 reg 5 still 1A5 (R3), R6 pointer to 3
        send(9'h155, 4'd3, 3'b001, 10);   // R4 short frame
        send(9'h155, 4'd3, 3'b001, 17);   // R4 long frame
        send(9'h0AA, 4'd9, 3'b001, 16);   // R5 reg 3 still 0F0 (R4)
        send(9'h009, 4'd0, 3'b001, 16);   // R6 pointer to 9
        send(9'h1FF, 4'd15, 3'b001, 16);  // R5 returns 0AA
        send(9'h000, 4'd1, 3'b001, 16);   // R5 returns 0AA again
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule